// File: doc/BRIEF.md
# MSI Snooping Cache Coherence Controller

This block is the coherence engine of one private, direct-mapped cache on a shared snooping bus. It holds the tag, data and three-state coherence tag (Invalid, Shared, Modified) of every frame. A processor port issues loads, stores and evictions. A bus request port asks the external arbiter for the bus, and a snoop port delivers the transactions of the other caches. Together they keep every copy of a line coherent under an invalidation protocol. A Modified owner sends its own line as the reply, and the memory stub captures that reply. A store to a Shared copy upgrades with a dataless invalidate. A clean line is dropped without any bus message.

An address is split into a word offset (low bits), a frame index and a tag. Bus and snoop addresses are line addresses (offset removed). The processor port stalls while its request waits for a grant or a fill. Snoops arriving during that wait are handled at once. The pending request is then re-planned against the updated frame, so an upgrade whose Shared copy was invalidated in the meantime becomes a read-exclusive.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset no frame holds a valid copy, `cpu_ready` is high while no snoop is present, and `bus_req`, `reply_valid` and `cpu_resp_valid` are low.
- R2: A load to a frame without a valid copy issues a read (cmd 1). It returns word `cpu_addr[0]` of the filled line, and the frame becomes Shared.
- R3: A store to a frame without a valid copy issues a read-exclusive (cmd 2). The store word is merged into the filled line, the other word is kept, and the frame becomes Modified.
- R4: A store that hits a Shared frame issues a dataless invalidate (cmd 3) and takes no fill. The response follows the grant, and the frame becomes Modified with the store merged in.
- R5: Loads hitting Shared or Modified frames and stores hitting Modified frames complete with no bus request. A response arrives one cycle after acceptance.
- R6: Evicting a Shared frame is silent. Evicting a Modified frame issues a write-back (cmd 4) carrying the line on `bus_wdata` at grant. Both leave the frame Invalid. Evicting an address whose tag does not match the frame has no effect.
- R7: A snooped read (cmd 1) that hits a Modified frame drives `reply_valid` with the line on the next cycle and leaves the frame Shared.
- R8: A snooped read-exclusive (cmd 2) on a Modified frame replies with the line and invalidates the frame. A snooped read-exclusive or invalidate (cmd 3) on a Shared frame invalidates it with no reply. A snooped read on a Shared frame changes nothing and gives no reply.
- R9: A snoop whose tag differs from the frame's, or that addresses an Invalid frame, causes no reply and no state change.
- R10: From acceptance of a request that needs the bus until its response, `cpu_ready` is low and `bus_req` holds its command and address until granted. Snoops during this wait are serviced, including replies.
- R11: A miss whose frame holds another line in Modified first writes that victim back (cmd 4), then issues its own read or read-exclusive. A Shared victim is dropped silently.
- R12: A pending request is re-planned after every snoop. An upgrade whose Shared copy is invalidated before grant is issued as a read-exclusive instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_op | input | 2 | 0 load, 1 store, 2 evict |
| cpu_addr | input | ADDR_W | Word address: offset, index, tag from low to high |
| cpu_wdata | input | DATA_W | Store word |
| cpu_ready | output | 1 | Request accepted on a cycle with cpu_valid high |
| cpu_resp_valid | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Load result word |
| bus_req | output | 1 | Bus transaction requested |
| bus_cmd | output | 3 | 1 read, 2 read-exclusive, 3 invalidate, 4 write-back |
| bus_addr | output | ADDR_W-1 | Line address of the request |
| bus_wdata | output | LINE_W | Victim line for a write-back |
| bus_gnt | input | 1 | Arbiter grant for the current request |
| bus_fill_valid | input | 1 | Fill data for a pending read or read-exclusive |
| bus_fill_data | input | LINE_W | Fill line |
| snoop_valid | input | 1 | Transaction from another cache |
| snoop_cmd | input | 3 | Snooped command, same coding as bus_cmd |
| snoop_addr | input | ADDR_W-1 | Snooped line address |
| reply_valid | output | 1 | This cache supplies a line |
| reply_data | output | LINE_W | Supplied line |

## Verification
The processor path runs a sequence of loads, stores and evictions that walks every frame state through every local transition. Because one sequence covers them all, a wrong next state shows up as a wrong bus command or a wrong word later on. Write-backs of merged lines are read again after the frame is refilled, so the data path is checked beyond the state bits. Snoops of each command hit Modified, Shared and Invalid frames and also miss on the tag. Each snoop is followed by a processor access whose bus command reveals the state the snoop left. Two overlap cases place a snoop inside a pending request: one separates replies during a stall from ordinary ones, and the other separates a stale upgrade from a correctly re-planned read-exclusive.

// File: rtl/msi_pkg.sv
package msi_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_M = 2'd2
    } line_state_e;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_EVICT = 2'd2
    } cpu_op_e;

    typedef enum logic [2:0] {
        CMD_NONE = 3'd0,
        CMD_RD   = 3'd1,
        CMD_RDX  = 3'd2,
        CMD_INV  = 3'd3,
        CMD_WB   = 3'd4
    } bus_cmd_e;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_REQ  = 2'd1,
        FS_FILL = 2'd2
    } fsm_state_e;

    // Bus step still needed for a processor request against the frame
    // as it stands now; CMD_NONE means it can finish locally.
    function automatic bus_cmd_e plan_action(cpu_op_e op, line_state_e st, logic tag_eq);
        bus_cmd_e r;
        r = CMD_NONE;
        if (op == OP_EVICT) begin
            if (tag_eq && st == ST_M) r = CMD_WB;
        end else if (op == OP_LOAD || op == OP_STORE) begin
            if (st != ST_I && !tag_eq) begin
                // foreign line: dirty victims go back first, clean ones vanish
                if (st == ST_M) r = CMD_WB;
                else            r = (op == OP_LOAD) ? CMD_RD : CMD_RDX;
            end else if (st == ST_I) begin
                r = (op == OP_LOAD) ? CMD_RD : CMD_RDX;
            end else if (op == OP_STORE && st == ST_S) begin
                r = CMD_INV;
            end
        end
        return r;
    endfunction

    function automatic line_state_e snoop_next(line_state_e st, bus_cmd_e cmd);
        line_state_e r;
        r = st;
        case (cmd)
            CMD_RD:  if (st == ST_M) r = ST_S;
            CMD_RDX: r = ST_I;
            CMD_INV: r = ST_I;
            default: r = st;
        endcase
        return r;
    endfunction

    function automatic logic snoop_supplies(line_state_e st, bus_cmd_e cmd);
        return (st == ST_M) && (cmd == CMD_RD || cmd == CMD_RDX);
    endfunction

endpackage

// File: rtl/msi_frame_array.sv
module msi_frame_array
    import msi_pkg::*;
#(
    parameter int FRAMES = 4,
    parameter int TAG_W  = 5,
    parameter int LINE_W = 32,
    localparam int IDX_W = $clog2(FRAMES)
) (
    input  logic              clk,
    input  logic              rst,
    // read port for the processor side
    input  logic [IDX_W-1:0]  a_idx,
    output line_state_e       a_state,
    output logic [TAG_W-1:0]  a_tag,
    output logic [LINE_W-1:0] a_data,
    // read port for the snoop side
    input  logic [IDX_W-1:0]  b_idx,
    output line_state_e       b_state,
    output logic [TAG_W-1:0]  b_tag,
    output logic [LINE_W-1:0] b_data,
    // full write from the processor side (wins on the same frame)
    input  logic              w_en,
    input  logic [IDX_W-1:0]  w_idx,
    input  line_state_e       w_state,
    input  logic [TAG_W-1:0]  w_tag,
    input  logic [LINE_W-1:0] w_data,
    // state-only write from the snoop side
    input  logic              s_en,
    input  logic [IDX_W-1:0]  s_idx,
    input  line_state_e       s_state
);

    line_state_e       st_q   [FRAMES];
    logic [TAG_W-1:0]  tag_q  [FRAMES];
    logic [LINE_W-1:0] data_q [FRAMES];

    for (genvar f = 0; f < FRAMES; f++) begin : g_frame
        logic own_hit, snp_hit;
        assign own_hit = w_en && (w_idx == IDX_W'(f));
        assign snp_hit = s_en && (s_idx == IDX_W'(f));

        always_ff @(posedge clk) begin
            if (rst) begin
                st_q[f]   <= ST_I;
                tag_q[f]  <= '0;
                data_q[f] <= '0;
            end else if (own_hit) begin
                st_q[f]   <= w_state;
                tag_q[f]  <= w_tag;
                data_q[f] <= w_data;
            end else if (snp_hit) begin
                st_q[f]   <= s_state;
            end
        end
    end

    assign a_state = st_q[a_idx];
    assign a_tag   = tag_q[a_idx];
    assign a_data  = data_q[a_idx];
    assign b_state = st_q[b_idx];
    assign b_tag   = tag_q[b_idx];
    assign b_data  = data_q[b_idx];

endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
    import msi_pkg::*;
#(
    parameter int TAG_W  = 5,
    parameter int IDX_W  = 2,
    parameter int LINE_W = 32,
    localparam int LADDR_W = TAG_W + IDX_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               snoop_valid,
    input  logic [2:0]         snoop_cmd,
    input  logic [LADDR_W-1:0] snoop_addr,
    output logic [IDX_W-1:0]   rd_idx,
    input  line_state_e        fr_state,
    input  logic [TAG_W-1:0]   fr_tag,
    input  logic [LINE_W-1:0]  fr_data,
    output logic               s_en,
    output logic [IDX_W-1:0]   s_idx,
    output line_state_e        s_state,
    output logic               reply_valid,
    output logic [LINE_W-1:0]  reply_data
);

    bus_cmd_e cmd;
    logic     hit;
    logic     supply;

    assign cmd     = bus_cmd_e'(snoop_cmd);
    assign rd_idx  = snoop_addr[IDX_W-1:0];
    assign s_idx   = rd_idx;
    assign hit     = (fr_state != ST_I) && (fr_tag == snoop_addr[LADDR_W-1 -: TAG_W]);
    assign s_state = snoop_next(fr_state, cmd);
    assign s_en    = snoop_valid && hit && (s_state != fr_state);
    assign supply  = snoop_valid && hit && snoop_supplies(fr_state, cmd);

    always_ff @(posedge clk) begin
        if (rst) begin
            reply_valid <= 1'b0;
            reply_data  <= '0;
        end else begin
            reply_valid <= supply;
            if (supply) reply_data <= fr_data;
        end
    end

endmodule

// File: rtl/msi_req_fsm.sv
module msi_req_fsm
    import msi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int WORDS  = 2,
    parameter int FRAMES = 4,
    localparam int OFF_W   = $clog2(WORDS),
    localparam int IDX_W   = $clog2(FRAMES),
    localparam int TAG_W   = ADDR_W - OFF_W - IDX_W,
    localparam int LADDR_W = ADDR_W - OFF_W,
    localparam int LINE_W  = DATA_W * WORDS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cpu_valid,
    input  logic [1:0]         cpu_op,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [DATA_W-1:0]  cpu_wdata,
    output logic               cpu_ready,
    output logic               cpu_resp_valid,
    output logic [DATA_W-1:0]  cpu_rdata,
    input  logic               snoop_busy,
    output logic               bus_req,
    output logic [2:0]         bus_cmd,
    output logic [LADDR_W-1:0] bus_addr,
    output logic [LINE_W-1:0]  bus_wdata,
    input  logic               bus_gnt,
    input  logic               bus_fill_valid,
    input  logic [LINE_W-1:0]  bus_fill_data,
    output logic [IDX_W-1:0]   rd_idx,
    input  line_state_e        fr_state,
    input  logic [TAG_W-1:0]   fr_tag,
    input  logic [LINE_W-1:0]  fr_data,
    output logic               w_en,
    output logic [IDX_W-1:0]   w_idx,
    output line_state_e        w_state,
    output logic [TAG_W-1:0]   w_tag,
    output logic [LINE_W-1:0]  w_data
);

    function automatic logic [LINE_W-1:0] put_word(logic [LINE_W-1:0] line,
                                                   logic [OFF_W-1:0] off,
                                                   logic [DATA_W-1:0] w);
        logic [LINE_W-1:0] r;
        r = line;
        r[int'(off)*DATA_W +: DATA_W] = w;
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] get_word(logic [LINE_W-1:0] line,
                                                   logic [OFF_W-1:0] off);
        return line[int'(off)*DATA_W +: DATA_W];
    endfunction

    fsm_state_e        st_q;
    cpu_op_e           p_op;
    logic [TAG_W-1:0]  p_tag;
    logic [IDX_W-1:0]  p_idx;
    logic [OFF_W-1:0]  p_off;
    logic [DATA_W-1:0] p_wdata;
    logic              p_rdx;

    cpu_op_e           cur_op;
    logic [TAG_W-1:0]  cur_tag;
    logic [IDX_W-1:0]  cur_idx;
    logic [OFF_W-1:0]  cur_off;
    logic [DATA_W-1:0] cur_wdata;
    logic              tag_eq;
    bus_cmd_e          act;
    logic              quiet, take, local_go, gnt_go, fill_go, resp_fire;
    logic [DATA_W-1:0] resp_word;

    always_comb begin
        if (st_q == FS_IDLE) begin
            cur_op    = cpu_op_e'(cpu_op);
            cur_tag   = cpu_addr[ADDR_W-1 -: TAG_W];
            cur_idx   = cpu_addr[OFF_W +: IDX_W];
            cur_off   = cpu_addr[OFF_W-1:0];
            cur_wdata = cpu_wdata;
        end else begin
            cur_op    = p_op;
            cur_tag   = p_tag;
            cur_idx   = p_idx;
            cur_off   = p_off;
            cur_wdata = p_wdata;
        end
    end

    assign rd_idx = cur_idx;
    assign tag_eq = (fr_tag == cur_tag);
    assign act    = plan_action(cur_op, fr_state, tag_eq);

    // own-side steps wait for a cycle with no snoop, so a decision never
    // rests on a frame the snoop side is rewriting in the same edge
    assign quiet     = !snoop_busy;
    assign cpu_ready = (st_q == FS_IDLE) && quiet;
    assign take      = cpu_ready && cpu_valid;
    assign local_go  = quiet && ((st_q == FS_IDLE && cpu_valid) || st_q == FS_REQ)
                       && (act == CMD_NONE);
    assign gnt_go    = (st_q == FS_REQ) && quiet && (act != CMD_NONE) && bus_gnt;
    assign fill_go   = (st_q == FS_FILL) && bus_fill_valid;
    assign resp_fire = local_go || (gnt_go && act == CMD_INV) || fill_go;

    assign bus_req   = (st_q == FS_REQ) && (act != CMD_NONE);
    assign bus_cmd   = bus_req ? 3'(act) : 3'(CMD_NONE);
    assign bus_addr  = (act == CMD_WB) ? {fr_tag, cur_idx} : {cur_tag, cur_idx};
    assign bus_wdata = fr_data;

    always_comb begin
        w_en    = 1'b0;
        w_idx   = cur_idx;
        w_state = fr_state;
        w_tag   = fr_tag;
        w_data  = fr_data;
        if (local_go) begin
            if (cur_op == OP_STORE) begin
                w_en   = 1'b1;
                w_data = put_word(fr_data, cur_off, cur_wdata);
            end else if (cur_op == OP_EVICT && fr_state == ST_S && tag_eq) begin
                w_en    = 1'b1;
                w_state = ST_I;
            end
        end else if (gnt_go) begin
            if (act == CMD_WB) begin
                w_en    = 1'b1;
                w_state = ST_I;
            end else if (act == CMD_INV) begin
                w_en    = 1'b1;
                w_state = ST_M;
                w_data  = put_word(fr_data, cur_off, cur_wdata);
            end
        end else if (fill_go) begin
            w_en    = 1'b1;
            w_tag   = cur_tag;
            w_state = p_rdx ? ST_M : ST_S;
            w_data  = p_rdx ? put_word(bus_fill_data, cur_off, cur_wdata) : bus_fill_data;
        end
    end

    assign resp_word = (cur_op == OP_STORE) ? cur_wdata
                     : get_word(fill_go ? bus_fill_data : fr_data, cur_off);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q           <= FS_IDLE;
            p_op           <= OP_LOAD;
            p_tag          <= '0;
            p_idx          <= '0;
            p_off          <= '0;
            p_wdata        <= '0;
            p_rdx          <= 1'b0;
            cpu_resp_valid <= 1'b0;
            cpu_rdata      <= '0;
        end else begin
            cpu_resp_valid <= resp_fire;
            if (resp_fire) cpu_rdata <= resp_word;
            if (take) begin
                p_op    <= cur_op;
                p_tag   <= cur_tag;
                p_idx   <= cur_idx;
                p_off   <= cur_off;
                p_wdata <= cur_wdata;
            end
            case (st_q)
                FS_IDLE: if (take && act != CMD_NONE) st_q <= FS_REQ;
                FS_REQ: begin
                    if (local_go) begin
                        st_q <= FS_IDLE;
                    end else if (gnt_go) begin
                        if (act == CMD_INV) begin
                            st_q <= FS_IDLE;
                        end else if (act == CMD_RD || act == CMD_RDX) begin
                            st_q  <= FS_FILL;
                            p_rdx <= (act == CMD_RDX);
                        end
                    end
                end
                FS_FILL: if (fill_go) st_q <= FS_IDLE;
                default: st_q <= FS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
    import msi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int WORDS  = 2,
    parameter int FRAMES = 4
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  cpu_valid,
    input  logic [1:0]                            cpu_op,
    input  logic [ADDR_W-1:0]                     cpu_addr,
    input  logic [DATA_W-1:0]                     cpu_wdata,
    output logic                                  cpu_ready,
    output logic                                  cpu_resp_valid,
    output logic [DATA_W-1:0]                     cpu_rdata,
    output logic                                  bus_req,
    output logic [2:0]                            bus_cmd,
    output logic [ADDR_W-$clog2(WORDS)-1:0]       bus_addr,
    output logic [DATA_W*WORDS-1:0]               bus_wdata,
    input  logic                                  bus_gnt,
    input  logic                                  bus_fill_valid,
    input  logic [DATA_W*WORDS-1:0]               bus_fill_data,
    input  logic                                  snoop_valid,
    input  logic [2:0]                            snoop_cmd,
    input  logic [ADDR_W-$clog2(WORDS)-1:0]       snoop_addr,
    output logic                                  reply_valid,
    output logic [DATA_W*WORDS-1:0]               reply_data
);

    localparam int OFF_W   = $clog2(WORDS);
    localparam int IDX_W   = $clog2(FRAMES);
    localparam int TAG_W   = ADDR_W - OFF_W - IDX_W;
    localparam int LADDR_W = ADDR_W - OFF_W;
    localparam int LINE_W  = DATA_W * WORDS;

    logic [IDX_W-1:0]  a_idx, b_idx, w_idx, s_idx;
    line_state_e       a_state, b_state, w_state, s_state;
    logic [TAG_W-1:0]  a_tag, b_tag, w_tag;
    logic [LINE_W-1:0] a_data, b_data, w_data;
    logic              w_en, s_en;

    msi_frame_array #(.FRAMES(FRAMES), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_frames (
        .clk(clk), .rst(rst),
        .a_idx(a_idx), .a_state(a_state), .a_tag(a_tag), .a_data(a_data),
        .b_idx(b_idx), .b_state(b_state), .b_tag(b_tag), .b_data(b_data),
        .w_en(w_en), .w_idx(w_idx), .w_state(w_state), .w_tag(w_tag), .w_data(w_data),
        .s_en(s_en), .s_idx(s_idx), .s_state(s_state)
    );

    msi_req_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS), .FRAMES(FRAMES)) u_req (
        .clk(clk), .rst(rst),
        .cpu_valid(cpu_valid), .cpu_op(cpu_op), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_resp_valid(cpu_resp_valid), .cpu_rdata(cpu_rdata),
        .snoop_busy(snoop_valid),
        .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_gnt(bus_gnt), .bus_fill_valid(bus_fill_valid), .bus_fill_data(bus_fill_data),
        .rd_idx(a_idx), .fr_state(a_state), .fr_tag(a_tag), .fr_data(a_data),
        .w_en(w_en), .w_idx(w_idx), .w_state(w_state), .w_tag(w_tag), .w_data(w_data)
    );

    msi_snoop_unit #(.TAG_W(TAG_W), .IDX_W(IDX_W), .LINE_W(LINE_W)) u_snoop (
        .clk(clk), .rst(rst),
        .snoop_valid(snoop_valid), .snoop_cmd(snoop_cmd), .snoop_addr(snoop_addr),
        .rd_idx(b_idx), .fr_state(b_state), .fr_tag(b_tag), .fr_data(b_data),
        .s_en(s_en), .s_idx(s_idx), .s_state(s_state),
        .reply_valid(reply_valid), .reply_data(reply_data)
    );

endmodule

// File: rtl/msi_snoop_ctrl_chk.sv
module msi_snoop_ctrl_chk #(
    parameter int LADDR_W = 7
) (
    input logic               clk,
    input logic               rst,
    input logic               cpu_ready,
    input logic               cpu_resp_valid,
    input logic               bus_req,
    input logic [2:0]         bus_cmd,
    input logic [LADDR_W-1:0] bus_addr,
    input logic               bus_gnt,
    input logic               snoop_valid,
    input logic [2:0]         snoop_cmd,
    input logic               reply_valid
);

    AST_STALL_WHILE_REQ: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> !cpu_ready);  // R10

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_gnt && !snoop_valid) |=> (bus_req && $stable(bus_cmd) && $stable(bus_addr)));  // R10

    AST_RESP_FREES_BUS: assert property (@(posedge clk) disable iff (rst)
        cpu_resp_valid |-> !bus_req);  // R5

    AST_REPLY_NEEDS_READ: assert property (@(posedge clk) disable iff (rst)
        reply_valid |-> ($past(snoop_valid) && ($past(snoop_cmd) == 3'd1 || $past(snoop_cmd) == 3'd2)));  // R7

    AST_NO_REPLY_ON_INV: assert property (@(posedge clk) disable iff (rst)
        (snoop_valid && snoop_cmd == 3'd3) |=> !reply_valid);  // R8

endmodule

bind msi_snoop_ctrl msi_snoop_ctrl_chk #(.LADDR_W(LADDR_W)) u_chk (
    .clk(clk), .rst(rst), .cpu_ready(cpu_ready), .cpu_resp_valid(cpu_resp_valid),
    .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_gnt(bus_gnt),
    .snoop_valid(snoop_valid), .snoop_cmd(snoop_cmd), .reply_valid(reply_valid)
);

// File: tb/test_msi_snoop_ctrl.sv
module test_msi_snoop_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;
    localparam int LADDR_W = ADDR_W - 1;
    localparam int LINE_W = 2 * DATA_W;
    localparam int NLINES = 1 << LADDR_W;

    localparam logic [1:0] LD = 2'd0, ST = 2'd1, EV = 2'd2;
    localparam logic [2:0] NO = 3'd0, RD = 3'd1, RDX = 3'd2, INV = 3'd3, WB = 3'd4;

    typedef struct packed {
        logic [1:0]        op;
        logic [7:0]        addr;
        logic [15:0]       wdata;
        logic [2:0]        c0;
        logic [2:0]        c1;
        logic [15:0]       exp;
        logic [3:0]        rq;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{LD, 8'h10, 16'h0000, RD, NO, 16'hA010, 4'd2},   // R2 cold load miss
        '{LD, 8'h11, 16'h0000, NO, NO, 16'hA011, 4'd5},   // R5 load hit Shared
        '{ST, 8'h11, 16'h1234, INV, NO, 16'h0000, 4'd4},  // R4 upgrade
        '{LD, 8'h11, 16'h0000, NO, NO, 16'h1234, 4'd5},   // R5 load hit Modified
        '{LD, 8'h10, 16'h0000, NO, NO, 16'hA010, 4'd4},   // R4 other word kept
        '{ST, 8'h10, 16'h5678, NO, NO, 16'h0000, 4'd5},   // R5 store hit Modified
        '{ST, 8'h32, 16'hBEEF, RDX, NO, 16'h0000, 4'd3},  // R3 store miss
        '{LD, 8'h33, 16'h0000, NO, NO, 16'hA033, 4'd3},   // R3 merge kept fill word
        '{LD, 8'h32, 16'h0000, NO, NO, 16'hBEEF, 4'd3},
        '{LD, 8'h90, 16'h0000, WB, RD, 16'hA090, 4'd11},  // R11 dirty victim first
        '{LD, 8'h10, 16'h0000, RD, NO, 16'h5678, 4'd11},  // R11 clean victim silent
        '{LD, 8'h11, 16'h0000, NO, NO, 16'h1234, 4'd6},
        '{EV, 8'h10, 16'h0000, NO, NO, 16'h0000, 4'd6},   // R6 silent evict
        '{LD, 8'h11, 16'h0000, RD, NO, 16'h1234, 4'd6},
        '{EV, 8'h32, 16'h0000, WB, NO, 16'h0000, 4'd6},   // R6 dirty evict
        '{LD, 8'h32, 16'h0000, RD, NO, 16'hBEEF, 4'd6},
        '{EV, 8'h50, 16'h0000, NO, NO, 16'h0000, 4'd6},   // R6 tag mismatch
        '{LD, 8'h10, 16'h0000, NO, NO, 16'h5678, 4'd6}
    };

    logic clk = 1'b0, rst = 1'b1;
    logic cpu_valid = 1'b0;
    logic [1:0] cpu_op = '0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [DATA_W-1:0] cpu_wdata = '0;
    logic cpu_ready, cpu_resp_valid;
    logic [DATA_W-1:0] cpu_rdata;
    logic bus_req;
    logic [2:0] bus_cmd;
    logic [LADDR_W-1:0] bus_addr;
    logic [LINE_W-1:0] bus_wdata;
    logic bus_gnt = 1'b0, bus_fill_valid = 1'b0;
    logic [LINE_W-1:0] bus_fill_data = '0;
    logic snoop_valid = 1'b0;
    logic [2:0] snoop_cmd = '0;
    logic [LADDR_W-1:0] snoop_addr = '0;
    logic reply_valid;
    logic [LINE_W-1:0] reply_data;

    int errors = 0, checks = 0;
    logic [LINE_W-1:0] mem [NLINES];
    logic [2:0] seen [3];
    int nseen;
    logic [DATA_W-1:0] got;

    always #(CLK_PERIOD/2) clk = ~clk;

    msi_snoop_ctrl i_msi_snoop_ctrl (
        .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_op(cpu_op), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_resp_valid(cpu_resp_valid),
        .cpu_rdata(cpu_rdata), .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_gnt(bus_gnt), .bus_fill_valid(bus_fill_valid),
        .bus_fill_data(bus_fill_data), .snoop_valid(snoop_valid), .snoop_cmd(snoop_cmd),
        .snoop_addr(snoop_addr), .reply_valid(reply_valid), .reply_data(reply_data)
    );

    task automatic check(string rq, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic start_op(logic [1:0] op, logic [7:0] a, logic [15:0] wd);
        @(negedge clk);
        cpu_valid = 1'b1; cpu_op = op; cpu_addr = a; cpu_wdata = wd;
        while (!cpu_ready) @(negedge clk);
        @(negedge clk);
        cpu_valid = 1'b0;
    endtask

    // plays arbiter and memory until the response; records bus commands
    task automatic finish_op(string rq);
        logic [2:0] c;
        logic [LADDR_W-1:0] la;
        bit done = 0;
        nseen = 0;
        for (int k = 0; k < 40 && !done; k++) begin
            if (cpu_resp_valid) begin
                got = cpu_rdata;
                done = 1;
            end else if (bus_req) begin
                c = bus_cmd; la = bus_addr;
                if (nseen < 3) seen[nseen] = c;
                nseen++;
                if (c == WB) mem[la] = bus_wdata;
                bus_gnt = 1'b1;
                @(negedge clk);
                bus_gnt = 1'b0;
                if (c == RD || c == RDX) begin
                    bus_fill_valid = 1'b1; bus_fill_data = mem[la];
                    @(negedge clk);
                    bus_fill_valid = 1'b0;
                end
            end else begin
                @(negedge clk);
            end
        end
        if (!done) check(rq, "no response", 64'd0, 64'd1);
    endtask

    task automatic cmds_are(string rq, logic [2:0] c0, logic [2:0] c1);
        int n;
        n = (c0 != NO) + (c1 != NO);
        check(rq, "bus command count", 64'(nseen), 64'(n));
        if (n > 0 && nseen > 0) check(rq, "first bus command", 64'(seen[0]), 64'(c0));
        if (n > 1 && nseen > 1) check(rq, "second bus command", 64'(seen[1]), 64'(c1));
    endtask

    task automatic snoop(logic [2:0] c, logic [LADDR_W-1:0] la, logic exp_rep,
                         logic [LINE_W-1:0] exp_line, string rq);
        @(negedge clk);
        snoop_valid = 1'b1; snoop_cmd = c; snoop_addr = la;
        @(negedge clk);
        snoop_valid = 1'b0;
        check(rq, "reply_valid", 64'(reply_valid), 64'(exp_rep));
        if (reply_valid) begin
            mem[la] = reply_data;   // memory snarfs the owner's reply
            if (exp_rep) check(rq, "reply_data", 64'(reply_data), 64'(exp_line));
        end
    endtask

    task automatic access(logic [1:0] op, logic [7:0] a, logic [15:0] wd,
                          logic [2:0] c0, logic [2:0] c1, logic [15:0] exp, string rq);
        start_op(op, a, wd);
        finish_op(rq);
        cmds_are(rq, c0, c1);
        if (op == LD) check(rq, "load data", 64'(got), 64'(exp));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < NLINES; i++)
            mem[i] = {16'hA000 | 16'((i << 1) | 1), 16'hA000 | 16'(i << 1)};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset outputs
        check("R1", "cpu_ready", 64'(cpu_ready), 64'd1);
        check("R1", "bus_req", 64'(bus_req), 64'd0);
        check("R1", "reply_valid", 64'(reply_valid), 64'd0);
        check("R1", "cpu_resp_valid", 64'(cpu_resp_valid), 64'd0);

        for (int v = 0; v < NV; v++) begin
            string rq;
            rq = $sformatf("R%0d vec%0d", VECS[v].rq, v);
            access(VECS[v].op, VECS[v].addr, VECS[v].wdata, VECS[v].c0, VECS[v].c1,
                   VECS[v].exp, rq);
        end

        // frame0 holds line 8 Shared, frame1 holds line 25 Shared
        snoop(RD, 7'd8, 1'b0, '0, "R8 read on Shared");
        access(LD, 8'h10, 0, NO, NO, 16'h5678, "R8 still Shared");
        snoop(RDX, 7'd8, 1'b0, '0, "R8 rdx on Shared");
        access(LD, 8'h10, 0, RD, NO, 16'h5678, "R8 invalidated");
        access(ST, 8'h12, 16'hC0DE, RDX, NO, 0, "R3 R11 clean victim");
        snoop(RD, 7'd9, 1'b1, {16'hA013, 16'hC0DE}, "R7 owner reply");
        access(ST, 8'h13, 16'h1313, INV, NO, 0, "R7 left Shared");
        snoop(RDX, 7'd9, 1'b1, {16'h1313, 16'hC0DE}, "R8 owner rdx");
        access(LD, 8'h12, 0, RD, NO, 16'hC0DE, "R8 owner invalidated");
        snoop(RDX, 7'd41, 1'b0, '0, "R9 tag miss");
        access(LD, 8'h12, 0, NO, NO, 16'hC0DE, "R9 frame untouched");
        snoop(RD, 7'd3, 1'b0, '0, "R9 invalid frame");

        // R10 R12: upgrade pending, snoop steals the Shared copy
        start_op(ST, 8'h13, 16'h7777);
        check("R10", "bus_req while waiting", 64'(bus_req), 64'd1);
        check("R10", "cpu_ready while waiting", 64'(cpu_ready), 64'd0);
        check("R4", "pending command", 64'(bus_cmd), 64'(INV));
        snoop(RDX, 7'd9, 1'b0, '0, "R10 snoop in wait");
        check("R12", "replanned command", 64'(bus_cmd), 64'(RDX));
        finish_op("R12");
        cmds_are("R12", RDX, NO);
        access(LD, 8'h12, 0, NO, NO, 16'hC0DE, "R12 fill merged");
        access(LD, 8'h13, 0, NO, NO, 16'h7777, "R12 store merged");

        // R10: reply given while own miss is pending
        start_op(LD, 8'h14, 0);
        check("R10", "miss pending", 64'(bus_cmd), 64'(RD));
        snoop(RD, 7'd9, 1'b1, {16'h7777, 16'hC0DE}, "R10 reply during stall");
        finish_op("R10");
        cmds_are("R10", RD, NO);
        check("R10", "load data", 64'(got), 64'hA014);
        access(ST, 8'h13, 16'h8888, INV, NO, 0, "R7 demoted during stall");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule